// File: doc/BRIEF.md
# Bridge-Steered PWM Generator

This block produces one pulse-width-modulated waveform with 10-bit duty resolution and routes it to four output channels, A to D, for driving single loads, half bridges or full bridges. A 2-bit steering mode selects which channels carry the waveform, which are held at a fixed level and which are released for other use. A 2-bit polarity code sets the active level of two channel pairs, A/C and B/D. In half-bridge mode the A/B pair is complementary, and a programmable dead band separates the two active phases.

Software sets the period, the duty, the control fields and the dead band through a simple write port. A new period, duty, mode or polarity takes effect only when the period counter wraps, so no period is ever cut short or stretched part-way. A per-channel drive-enable output shows which channels the generator owns. Clearing the enable bit stops the counter and forces every channel to its inactive level.

Top module: `pwm_bridge_steer`

## Requirements
- R1: The duty value D is 10 bits: bits 9:2 come from register address 1 (wr_data[7:0]) and bits 1:0 from control bits 1:0. With period value P, channel A in mode 00 is active for min(D, P+1) clocks in every period, so D=0 gives 0% and any D above P gives 100%.
- R2: One PWM period lasts P+1 clocks, where P is written at address 0 (wr_data[9:0]). The internal counter never exceeds the period value in use.
- R3: In mode 00, only channel A carries the PWM. B, C and D stay inactive, and ch_drive reads 4'b0001. Bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D.
- R4: In mode 01, channel D carries the PWM, A is held active, B and C are held inactive, and ch_drive reads 4'b1111.
- R5: In mode 11, channel B carries the PWM, C is held active, A and D are held inactive, and ch_drive reads 4'b1111.
- R6: In mode 10, A and B form a complementary pair and are never active together. C and D stay inactive, and ch_drive reads 4'b0011.
- R7: Polarity code bit 1 makes A and C active-low, and bit 0 makes B and D active-low. Code 00 makes all four channels active-high, and code 11 makes all four active-low.
- R8: In mode 10, each rising edge of A and each rising edge of B is delayed by the dead-band count N (0..127). A is active for D-N clocks per period and B for P+1-D-N clocks, provided N is below both phase lengths.
- R9: A write to period, duty, mode or polarity while the block is enabled takes effect only at the next counter wrap. The period that is already running finishes with the old values.
- R10: While the enable bit is clear, and after reset, every channel drives its inactive level, ch_drive reads 4'b1111, and the counter is held at zero.
- R11: The write port is decoded as follows:
  - address 0: period.
  - address 1: duty bits 9:2.
  - address 2: control. Bits 1:0 are the duty LSBs, bits 3:2 the polarity, bits 5:4 the mode, and bit 6 the enable.
  - address 3: dead-band count, in bits 6:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 10 | Write data |
| ch_out | output | 4 | Channel levels, bit 0 = A to bit 3 = D |
| ch_drive | output | 4 | Per-channel drive enable (1 = owned by the PWM) |

## Verification
A register write lands one edge after the strobe. The shadow copies load at the next counter wrap. The channel outputs then lag the counter by three registers: the comparator, the dead-band stage and the output stage. For this reason the bench waits three full periods plus a margin after any configuration change. It then counts active cycles over exactly P+1 clocks, and because the waveform is periodic, that count does not depend on where the window starts. The shadow-update check instead times a single pulse, measuring from its rising edge to its falling edge after a mid-period write. This run length is compared with the old duty, then the next pulse is compared with the new one. Static levels under disable are sampled a few clocks after the enable write, past the one output register.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_FWD    = 2'b01,
    MODE_HALF   = 2'b10,
    MODE_REV    = 2'b11
  } steer_mode_e;

  localparam logic [1:0] ADDR_PERIOD = 2'd0;
  localparam logic [1:0] ADDR_DUTY   = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_DEAD   = 2'd3;

  localparam int NUM_CH = 4;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_steer_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DB_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] per_r,
  output logic [CNT_W-1:0] duty_r,
  output steer_mode_e      mode_r,
  output logic [1:0]       pol_r,
  output logic             en_r,
  output logic [DB_W-1:0]  db_r
);

  // control word: [1:0] duty lsb, [3:2] polarity, [5:4] mode, [6] enable (R11)
  always_ff @(posedge clk) begin
    if (rst) begin
      per_r  <= '0;
      duty_r <= '0;
      mode_r <= MODE_SINGLE;
      pol_r  <= 2'b00;
      en_r   <= 1'b0;
      db_r   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_PERIOD: per_r <= wr_data;
        ADDR_DUTY:   duty_r[CNT_W-1:2] <= wr_data[CNT_W-3:0];
        ADDR_CTRL: begin
          duty_r[1:0] <= wr_data[1:0];
          pol_r       <= wr_data[3:2];
          mode_r      <= steer_mode_e'(wr_data[5:4]);
          en_r        <= wr_data[6];
        end
        default:     db_r <= wr_data[DB_W-1:0];
      endcase
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_steer_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] per_r,
  input  logic [CNT_W-1:0] duty_r,
  input  steer_mode_e      mode_r,
  input  logic [1:0]       pol_r,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_sh,
  output logic [CNT_W-1:0] duty_sh,
  output steer_mode_e      mode_sh,
  output logic [1:0]       pol_sh,
  output logic             raw_q
);

  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic wrap;
  assign wrap = (cnt == per_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      per_sh  <= '0;
      duty_sh <= '0;
      mode_sh <= MODE_SINGLE;
      pol_sh  <= 2'b00;
      raw_q   <= 1'b0;
    end else begin
      // shadows follow the registers while idle, otherwise only at a wrap
      if (!en || wrap) begin
        per_sh  <= per_r;
        duty_sh <= duty_r;
        mode_sh <= mode_r;
        pol_sh  <= pol_r;
      end
      if (!en || wrap) cnt <= '0;
      else             cnt <= cnt + CNT_ONE;
      raw_q <= en && (cnt < duty_sh);
    end
  end

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
  parameter int DB_W = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            raw,
  input  logic [DB_W-1:0] db,
  output logic            mod_q,
  output logic            a_q,
  output logic            b_q
);

  localparam logic [DB_W-1:0] DB_ONE = 1;

  logic            prev;
  logic [DB_W-1:0] dcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b0;
      mod_q <= 1'b0;
      dcnt  <= '0;
      a_q   <= 1'b0;
      b_q   <= 1'b0;
    end else begin
      prev  <= raw;
      mod_q <= raw;
      if (raw != prev) begin
        // edge of the source: both sides off for db clocks, then follow
        if (db == '0) begin
          a_q  <= raw;
          b_q  <= !raw;
          dcnt <= '0;
        end else begin
          a_q  <= 1'b0;
          b_q  <= 1'b0;
          dcnt <= db - DB_ONE;
        end
      end else if (dcnt != '0) begin
        dcnt <= dcnt - DB_ONE;
        a_q  <= 1'b0;
        b_q  <= 1'b0;
      end else begin
        a_q <= raw;
        b_q <= !raw;
      end
    end
  end

endmodule

// File: rtl/pwm_bridge_steer.sv
module pwm_bridge_steer
  import pwm_steer_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DB_W  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [3:0]       ch_out,
  output logic [3:0]       ch_drive
);

  logic [CNT_W-1:0] per_r, duty_r, cnt, per_sh, duty_sh;
  steer_mode_e      mode_r, mode_sh;
  logic [1:0]       pol_r, pol_sh;
  logic             en_r, raw_q, mod_q, a_q, b_q;
  logic [DB_W-1:0]  db_r;

  pwm_regfile #(.CNT_W(CNT_W), .DB_W(DB_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .per_r(per_r), .duty_r(duty_r), .mode_r(mode_r), .pol_r(pol_r),
    .en_r(en_r), .db_r(db_r)
  );

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .en(en_r), .per_r(per_r), .duty_r(duty_r),
    .mode_r(mode_r), .pol_r(pol_r), .cnt(cnt), .per_sh(per_sh),
    .duty_sh(duty_sh), .mode_sh(mode_sh), .pol_sh(pol_sh), .raw_q(raw_q)
  );

  pwm_deadband #(.DB_W(DB_W)) u_db (
    .clk(clk), .rst(rst), .raw(raw_q), .db(db_r),
    .mod_q(mod_q), .a_q(a_q), .b_q(b_q)
  );

  // logical activity per channel and ownership, bit 0 = A .. bit 3 = D
  logic [3:0] act, drv, low_lvl;

  always_comb begin
    act = 4'b0000;
    drv = 4'b1111;
    if (en_r) begin
      case (mode_sh)
        MODE_SINGLE: begin act = {3'b000, mod_q};            drv = 4'b0001; end
        MODE_FWD:    begin act = {mod_q, 2'b00, 1'b1};       drv = 4'b1111; end
        MODE_HALF:   begin act = {2'b00, b_q, a_q};          drv = 4'b0011; end
        default:     begin act = {1'b0, 1'b1, mod_q, 1'b0};  drv = 4'b1111; end
      endcase
    end
  end

  // pairs: even channels (A, C) follow pol bit 1, odd (B, D) follow pol bit 0
  for (genvar g = 0; g < NUM_CH; g++) begin : g_pol
    if ((g % 2) == 1) begin : g_bd
      assign low_lvl[g] = pol_sh[0];
    end else begin : g_ac
      assign low_lvl[g] = pol_sh[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_out   <= 4'b0000;
      ch_drive <= 4'b1111;
    end else begin
      ch_out   <= act ^ low_lvl;
      ch_drive <= drv;
    end
  end

endmodule

// File: rtl/pwm_bridge_steer_chk.sv
module pwm_bridge_steer_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [1:0]       mode_sh,
  input logic [1:0]       pol_sh,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_sh,
  input logic [CNT_W-1:0] duty_sh,
  input logic [3:0]       ch_out,
  input logic [3:0]       ch_drive
);

  logic [3:0] lm;
  assign lm = {pol_sh[0], pol_sh[1], pol_sh[0], pol_sh[1]};

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= per_sh);

  p_single_r3: assert property (@(posedge clk) disable iff (rst)
    (en && mode_sh == 2'b00) |=>
      (ch_drive == 4'b0001) && (((ch_out ^ $past(lm)) & 4'b1110) == 4'b0000));

  p_fwd_r4: assert property (@(posedge clk) disable iff (rst)
    (en && mode_sh == 2'b01) |=>
      (ch_drive == 4'b1111) && (((ch_out ^ $past(lm)) & 4'b0111) == 4'b0001));

  p_rev_r5: assert property (@(posedge clk) disable iff (rst)
    (en && mode_sh == 2'b11) |=>
      (ch_drive == 4'b1111) && (((ch_out ^ $past(lm)) & 4'b1101) == 4'b0100));

  p_half_excl_r6: assert property (@(posedge clk) disable iff (rst)
    (en && mode_sh == 2'b10) |=>
      (ch_drive == 4'b0011) && (((ch_out ^ $past(lm)) & 4'b0011) != 4'b0011)
      && (((ch_out ^ $past(lm)) & 4'b1100) == 4'b0000));

  p_shadow_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty_sh) |-> (!$past(en) || ($past(cnt) == $past(per_sh))));

  p_idle_inactive_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (ch_drive == 4'b1111) && (ch_out == $past(lm)) && (cnt == '0));

endmodule

bind pwm_bridge_steer pwm_bridge_steer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .en(en_r), .mode_sh(mode_sh), .pol_sh(pol_sh),
  .cnt(cnt), .per_sh(per_sh), .duty_sh(duty_sh),
  .ch_out(ch_out), .ch_drive(ch_drive)
);

// File: tb/tb_pwm_bridge_steer.sv
`timescale 1ns/1ps
module tb_pwm_bridge_steer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [9:0] wr_data = 10'd0;
  logic [3:0] ch_out, ch_drive;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_bridge_steer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ch_out(ch_out), .ch_drive(ch_drive)
  );

  task automatic chk(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R11 field layout
  task automatic cfg(input int per, input int duty, input int mode,
                     input int pol, input int db, input bit en);
    wr(2'd0, 10'(per));
    wr(2'd3, 10'(db));
    wr(2'd1, 10'(duty >> 2));
    wr(2'd2, {3'b000, en, 2'(mode), 2'(pol), 2'(duty)});
  endtask

  // R7: active-low mask, A/C from pol bit 1, B/D from pol bit 0
  function automatic logic [3:0] lmask(input int pol);
    logic [1:0] p = 2'(pol);
    return {p[0], p[1], p[0], p[1]};
  endfunction

  task automatic settle(input int per);
    repeat (3 * (per + 1) + 8) @(negedge clk);
  endtask

  task automatic measure(input int per, input int pol,
                         output int ca, output int cb, output int cc, output int cd);
    logic [3:0] a;
    ca = 0; cb = 0; cc = 0; cd = 0;
    repeat (per + 1) begin
      @(negedge clk);
      a = ch_out ^ lmask(pol);
      ca += int'(a[0]); cb += int'(a[1]); cc += int'(a[2]); cd += int'(a[3]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog got=%0d exp=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int ca, cb, cc, cd, t0, run;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state: active-high polarity, so inactive is 0
    chk("R10 reset out", int'(ch_out), 0);
    chk("R10 reset drive", int'(ch_drive), 15);

    // R1/R3 duty sweep across 0..P+3 in single mode
    for (int d = 0; d <= 22; d++) begin
      cfg(19, d, 0, 0, 0, 1'b1);
      settle(19);
      measure(19, 0, ca, cb, cc, cd);
      chk("R1 duty count A", ca, (d < 20) ? d : 20);
      chk("R3 BCD inactive", cb + cc + cd, 0);
      chk("R3 drive", int'(ch_drive), 1);
    end

    // R2 period length from rising edge to rising edge
    for (int k = 0; k < 2; k++) begin
      automatic int per = (k == 0) ? 9 : 30;
      cfg(per, 5, 0, 0, 0, 1'b1);
      settle(per);
      do @(negedge clk); while (ch_out[0] !== 1'b0);
      do @(negedge clk); while (ch_out[0] !== 1'b1);
      t0 = cyc;
      do @(negedge clk); while (ch_out[0] !== 1'b0);
      do @(negedge clk); while (ch_out[0] !== 1'b1);
      chk("R2 period", cyc - t0, per + 1);
    end

    // R4/R5/R7 full-bridge modes under every polarity code
    for (int pol = 0; pol < 4; pol++) begin
      cfg(19, 8, 1, pol, 0, 1'b1);
      settle(19);
      measure(19, pol, ca, cb, cc, cd);
      chk("R4 R7 fwd A held", ca, 20);
      chk("R4 R7 fwd BC off", cb + cc, 0);
      chk("R4 R7 fwd D duty", cd, 8);
      chk("R4 drive", int'(ch_drive), 15);
      cfg(19, 8, 3, pol, 0, 1'b1);
      settle(19);
      measure(19, pol, ca, cb, cc, cd);
      chk("R5 R7 rev B duty", cb, 8);
      chk("R5 R7 rev C held", cc, 20);
      chk("R5 R7 rev AD off", ca + cd, 0);
      chk("R5 drive", int'(ch_drive), 15);
    end

    // R6/R8 half bridge with dead band
    for (int k = 0; k < 8; k++) begin
      automatic int db   = (k % 4 == 0) ? 0 : (k % 4 == 1) ? 3 : (k % 4 == 2) ? 7 : 5;
      automatic int duty = (k % 4 == 3) ? 12 : 20;
      automatic int pol  = (k < 4) ? 0 : 3;
      cfg(39, duty, 2, pol, db, 1'b1);
      settle(39);
      measure(39, pol, ca, cb, cc, cd);
      chk("R8 A on time", ca, duty - db);
      chk("R8 B on time", cb, 40 - duty - db);
      chk("R6 CD off", cc + cd, 0);
      chk("R6 drive", int'(ch_drive), 3);
    end

    // R9 mid-period duty write waits for the wrap
    cfg(49, 12, 0, 0, 0, 1'b1);
    settle(49);
    do @(negedge clk); while (ch_out[0] !== 1'b0);
    do @(negedge clk); while (ch_out[0] !== 1'b1);
    t0 = cyc;
    wr(2'd1, 10'd10);               // duty 40 (bits 9:2 = 10, lsb 0)
    do @(negedge clk); while (ch_out[0] !== 1'b0);
    run = cyc - t0;
    chk("R9 current period keeps old duty", run, 12);
    do @(negedge clk); while (ch_out[0] !== 1'b1);
    t0 = cyc;
    do @(negedge clk); while (ch_out[0] !== 1'b0);
    chk("R9 next period new duty", cyc - t0, 40);

    // R10 disable with mixed polarity: A/C active-low -> inactive 1
    cfg(19, 8, 1, 2, 0, 1'b0);
    repeat (4) @(negedge clk);
    chk("R10 idle out", int'(ch_out), 5);
    chk("R10 idle drive", int'(ch_drive), 15);
    measure(19, 2, ca, cb, cc, cd);
    chk("R10 idle no activity", ca + cb + cc + cd, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule